// File: doc/BRIEF.md
# Background Gain Coefficient Estimator

This block learns gain correction coefficients while a converter keeps running. It watches a stream of signed output codes. It also drives the strobes that set the test condition of the next sample. The input is taken to be DC, so two neighbouring samples carry the same signal, and a known perturbation shows up as a difference between two codes. Calibration therefore runs in the background and conversion is never paused.

The block has two modes. In programmable-gain mode, every second sample carries an injected test level. The coefficient is the measured code step divided by the expected step `ref_step`. This expected step is the injected level over the ideal stage gain, written as a code. In fixed-gain mode, pairs of samples are taken with the fixed stage off and then on. Within each pair, the second sample has its input polarity reversed. Each pair difference is halved, and the coefficient is the ratio of the halved "on" difference to the halved "off" difference.

A multi-cycle restoring divider forms each coefficient. Every sample is then multiplied by the coefficient of the active mode, with rounding and saturation.

Sequencer states: `SQ_P_BASE` (next sample plain) → `SQ_P_INJ` (next sample injected) → back to `SQ_P_BASE`; `SQ_F_OFF_A` → `SQ_F_OFF_B` → `SQ_F_ON_A` → `SQ_F_ON_B` → back to `SQ_F_OFF_A`. Each transition happens on an accepted sample. If the mode input disagrees with the stored state, the state is read as the first state of the selected mode.

Divider states: `DV_IDLE` → `DV_RUN` on start; `DV_RUN` → `DV_DONE` after one step per dividend bit; `DV_DONE` → `DV_IDLE`.

Top module: `gain_coef_estimator`

## Requirements
- R1: After reset, both coefficient outputs are 0x400000 (1.0 in unsigned Q2.22), `out_valid` is 0, and all three strobes are 0.
- R2: In programmable-gain mode (`mode_fixed`=0), `inject_en` is 0 before the first sample of a pair and 1 before the second. `stage_on` and `swap_pol` stay 0 in this mode.
- R3: In fixed-gain mode, `inject_en` stays 0. Before the four samples of a cycle, {`stage_on`,`swap_pol`} reads 00, 01, 10, 11 in turn.
- R4: After a programmable-gain pair Y1, Y2 with `ref_step` nonzero, `pga_coef` becomes floor(|Y2−Y1|·2^22 / `ref_step`). Any value of 2^24 or more saturates to 0xFFFFFF.
- R5: After a fixed-gain cycle A,B (off) and C,D (on), let h_off=(A−B)>>>1 and h_on=(C−D)>>>1, using arithmetic (floor) halving. If h_off is nonzero, `fga_coef` becomes floor(|h_on|·2^22/|h_off|), saturated as in R4.
- R6: A division whose denominator is zero (`ref_step`=0, or h_off=0) is skipped, and the previous coefficient is kept.
- R7: Each sample yields `out_valid` on the next cycle. `out_code` = floor((code·coef + 2^21)/2^22), where coef is the active mode's coefficient as it stood when the sample was accepted.
- R8: A change of `mode_fixed` restarts the sequence at the first state of the new mode, so the strobes immediately show that state.
- R9: `out_code` saturates to the 24-bit signed range [−0x800000, 0x7FFFFF].
- R10: A coefficient output changes only when a division completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fixed | input | 1 | 0 = programmable-gain calibration, 1 = fixed-gain calibration |
| ref_step | input | 24 | Expected code step of the injected level at ideal gain (unsigned) |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 24 | Signed converter output code |
| inject_en | output | 1 | Next sample carries the injected test level |
| stage_on | output | 1 | Next sample taken with the fixed-gain stage enabled |
| swap_pol | output | 1 | Next sample taken with input polarity reversed |
| pga_coef | output | 24 | Programmable-gain coefficient, unsigned Q2.22 |
| fga_coef | output | 24 | Fixed-gain coefficient, unsigned Q2.22 |
| out_valid | output | 1 | Corrected code valid |
| out_code | output | 24 | Corrected signed code |

## Verification
The hardest case to reach is a fixed-gain cycle that is cut short by a mode switch. The stored sequencer state then belongs to the other mode, and only the mode input brings the strobes back in line. The stimulus switches modes halfway through a pair in both directions. It then checks that the strobes show the first state of the new mode before the next sample, and that the following pair yields the expected coefficient. Zero denominators and odd, negative halved differences are also driven on purpose, because they exercise the skip path and the floor halving.

// File: rtl/gce_pkg.sv
package gce_pkg;
    typedef enum logic [2:0] {
        SQ_P_BASE,
        SQ_P_INJ,
        SQ_F_OFF_A,
        SQ_F_OFF_B,
        SQ_F_ON_A,
        SQ_F_ON_B
    } seq_state_t;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_RUN,
        DV_DONE
    } div_state_t;
endpackage

// File: rtl/gce_seq.sv
module gce_seq
    import gce_pkg::*;
#(
    parameter int CODE_W = 24,
    localparam int NUM_W = CODE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_fixed,
    input  logic [CODE_W-1:0]        ref_step,
    input  logic                     smp_valid,
    input  logic signed [CODE_W-1:0] smp_code,
    input  logic                     div_ready,
    output logic                     inject_en,
    output logic                     stage_on,
    output logic                     swap_pol,
    output logic                     div_start,
    output logic [NUM_W-1:0]         div_num,
    output logic [CODE_W-1:0]        div_den,
    output logic                     div_tgt
);
    seq_state_t state_q, eff, nxt;
    logic signed [CODE_W-1:0] hold_q, half_off_q;
    logic signed [NUM_W-1:0]  step_w, pair_w;
    logic signed [CODE_W-1:0] half_w;

    function automatic logic [NUM_W-1:0] mag(input logic signed [NUM_W-1:0] v);
        return v[NUM_W-1] ? NUM_W'(-v) : NUM_W'(v);
    endfunction

    always_comb begin
        eff = state_q;
        if (!mode_fixed && (state_q inside {SQ_F_OFF_A, SQ_F_OFF_B, SQ_F_ON_A, SQ_F_ON_B}))
            eff = SQ_P_BASE;
        if (mode_fixed && (state_q inside {SQ_P_BASE, SQ_P_INJ}))
            eff = SQ_F_OFF_A;
    end

    always_comb begin
        nxt = eff;
        if (smp_valid) begin
            unique case (eff)
                SQ_P_BASE:  nxt = SQ_P_INJ;
                SQ_P_INJ:   nxt = SQ_P_BASE;
                SQ_F_OFF_A: nxt = SQ_F_OFF_B;
                SQ_F_OFF_B: nxt = SQ_F_ON_A;
                SQ_F_ON_A:  nxt = SQ_F_ON_B;
                SQ_F_ON_B:  nxt = SQ_F_OFF_A;
                default:    nxt = SQ_P_BASE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_P_BASE;
        else        state_q <= nxt;
    end

    always_comb begin
        inject_en = 1'b0;
        stage_on  = 1'b0;
        swap_pol  = 1'b0;
        unique case (eff)
            SQ_P_BASE:  ;
            SQ_P_INJ:   inject_en = 1'b1;
            SQ_F_OFF_A: ;
            SQ_F_OFF_B: swap_pol = 1'b1;
            SQ_F_ON_A:  stage_on = 1'b1;
            SQ_F_ON_B:  begin stage_on = 1'b1; swap_pol = 1'b1; end
            default:    ;
        endcase
    end

    assign step_w = NUM_W'(smp_code) - NUM_W'(hold_q);
    assign pair_w = NUM_W'(hold_q) - NUM_W'(smp_code);
    assign half_w = CODE_W'(pair_w >>> 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            half_off_q <= '0;
            div_start  <= 1'b0;
            div_num    <= '0;
            div_den    <= '0;
            div_tgt    <= 1'b0;
        end else begin
            div_start <= 1'b0;
            if (smp_valid) begin
                unique case (eff)
                    SQ_P_BASE, SQ_F_OFF_A, SQ_F_ON_A: hold_q <= smp_code;
                    SQ_F_OFF_B: half_off_q <= half_w;
                    SQ_P_INJ: begin
                        if (ref_step != '0 && div_ready) begin
                            div_start <= 1'b1;
                            div_num   <= mag(step_w);
                            div_den   <= ref_step;
                            div_tgt   <= 1'b0;
                        end
                    end
                    SQ_F_ON_B: begin
                        if (half_off_q != '0 && div_ready) begin
                            div_start <= 1'b1;
                            div_num   <= mag(NUM_W'(half_w));
                            div_den   <= CODE_W'(mag(NUM_W'(half_off_q)));
                            div_tgt   <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_fixed_no_inject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fixed |-> !inject_en);
    assert_pga_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_fixed |-> (!stage_on && !swap_pol));
    assert_inject_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !mode_fixed && !inject_en) ##1 !mode_fixed |-> inject_en);
endmodule

// File: rtl/gce_div.sv
module gce_div
    import gce_pkg::*;
#(
    parameter int NUM_W  = 25,
    parameter int DEN_W  = 24,
    parameter int FRAC_W = 22,
    parameter int Q_W    = 24,
    localparam int DVD_W = NUM_W + FRAC_W,
    localparam int CNT_W = $clog2(DVD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             idle,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    div_state_t state_q, nxt;
    logic [DVD_W-1:0] dvd_q, q_q;
    logic [DEN_W-1:0] den_q, rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            DV_IDLE: if (start) nxt = DV_RUN;
            DV_RUN:  if (cnt_q == '0) nxt = DV_DONE;
            DV_DONE: nxt = DV_IDLE;
            default: nxt = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DV_IDLE;
        else        state_q <= nxt;
    end

    assign trial = {rem_q, dvd_q[DVD_W-1]};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            q_q   <= '0;
            den_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
        end else if (state_q == DV_IDLE && start) begin
            dvd_q <= {num, {FRAC_W{1'b0}}};
            q_q   <= '0;
            den_q <= den;
            rem_q <= '0;
            cnt_q <= CNT_W'(DVD_W - 1);
        end else if (state_q == DV_RUN) begin
            rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
            q_q   <= {q_q[DVD_W-2:0], fits};
            dvd_q <= dvd_q << 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (state_q == DV_IDLE);
    assign done = (state_q == DV_DONE);
    assign quo  = (|q_q[DVD_W-1:Q_W]) ? {Q_W{1'b1}} : q_q[Q_W-1:0];

    assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == DV_IDLE));
endmodule

// File: rtl/gce_mul.sv
module gce_mul #(
    parameter int CODE_W = 24,
    parameter int COEF_W = 24,
    parameter int FRAC_W = 22,
    localparam int PROD_W = CODE_W + COEF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [CODE_W-1:0] in_code,
    input  logic [COEF_W-1:0]        coef,
    output logic                     out_valid,
    output logic signed [CODE_W-1:0] out_code
);
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);
    localparam logic signed [PROD_W-1:0] MAXV = {{(PROD_W-CODE_W+1){1'b0}}, {(CODE_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] MINV = {{(PROD_W-CODE_W+1){1'b1}}, {(CODE_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod, scaled;
    logic signed [CODE_W-1:0] clip;

    assign prod   = PROD_W'(in_code) * $signed({1'b0, coef});
    assign scaled = (prod + HALF) >>> FRAC_W;

    always_comb begin
        if (scaled > MAXV)      clip = MAXV[CODE_W-1:0];
        else if (scaled < MINV) clip = MINV[CODE_W-1:0];
        else                    clip = scaled[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_code <= clip;
        end
    end

    assert_out_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/gain_coef_estimator.sv
module gain_coef_estimator #(
    parameter int CODE_W = 24,
    parameter int FRAC_W = 22,
    localparam int COEF_W = CODE_W,
    localparam int NUM_W  = CODE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_fixed,
    input  logic [CODE_W-1:0]        ref_step,
    input  logic                     smp_valid,
    input  logic signed [CODE_W-1:0] smp_code,
    output logic                     inject_en,
    output logic                     stage_on,
    output logic                     swap_pol,
    output logic [COEF_W-1:0]        pga_coef,
    output logic [COEF_W-1:0]        fga_coef,
    output logic                     out_valid,
    output logic signed [CODE_W-1:0] out_code
);
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

    logic              div_start, div_tgt, div_idle, div_done, div_ready;
    logic [NUM_W-1:0]  div_num;
    logic [CODE_W-1:0] div_den;
    logic [COEF_W-1:0] div_quo;
    logic              tgt_q;

    assign div_ready = div_idle && !div_start;

    gce_seq #(.CODE_W(CODE_W)) u_seq (
        .clk, .rst_n, .mode_fixed, .ref_step, .smp_valid, .smp_code,
        .div_ready, .inject_en, .stage_on, .swap_pol,
        .div_start, .div_num, .div_den, .div_tgt
    );

    gce_div #(.NUM_W(NUM_W), .DEN_W(CODE_W), .FRAC_W(FRAC_W), .Q_W(COEF_W)) u_div (
        .clk, .rst_n, .start(div_start), .num(div_num), .den(div_den),
        .idle(div_idle), .done(div_done), .quo(div_quo)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pga_coef <= UNITY;
            fga_coef <= UNITY;
            tgt_q    <= 1'b0;
        end else begin
            if (div_start) tgt_q <= div_tgt;
            if (div_done) begin
                if (tgt_q) fga_coef <= div_quo;
                else       pga_coef <= div_quo;
            end
        end
    end

    gce_mul #(.CODE_W(CODE_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mul (
        .clk, .rst_n, .in_valid(smp_valid), .in_code(smp_code),
        .coef(mode_fixed ? fga_coef : pga_coef),
        .out_valid, .out_code
    );

    assert_coef_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !div_done |=> ($stable(pga_coef) && $stable(fga_coef)));
    assert_nonzero_den_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (div_den != '0));
endmodule

// File: tb/gain_coef_estimator_test.sv
module gain_coef_estimator_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_fixed = 1'b0;
    logic [23:0] ref_step = 24'h100000;
    logic smp_valid = 1'b0;
    logic signed [23:0] smp_code = '0;
    logic inject_en, stage_on, swap_pol, out_valid;
    logic [23:0] pga_coef, fga_coef;
    logic signed [23:0] out_code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    longint exp_q[$];
    string  tag_q[$];

    longint pga_m = 64'h400000;
    longint fga_m = 64'h400000;
    int ph = 0;
    longint hold = 0;
    longint half_off = 0;

    always #4 clk = ~clk;

    gain_coef_estimator uut (
        .clk, .rst_n, .mode_fixed, .ref_step, .smp_valid, .smp_code,
        .inject_en, .stage_on, .swap_pol, .pga_coef, .fga_coef,
        .out_valid, .out_code
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic longint quot(input longint n, input longint d);
        longint q;
        q = (n <<< 22) / d;
        return (q > 64'hFFFFFF) ? 64'hFFFFFF : q;
    endfunction

    function automatic longint corr(input longint code, input longint c);
        longint r;
        r = (code * c + 64'sd2097152) >>> 22;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic send(input bit fx, input int code, input string tag);
        int e;
        mode_fixed = fx;
        #1;
        if (!fx && ph >= 2) ph = 0;
        if (fx && ph < 2) ph = 2;
        e = ph;
        if (!fx) begin
            chk({tag, " R2 inject"}, inject_en, (e == 1));
            chk({tag, " R2 stage/swap"}, {stage_on, swap_pol}, 0);
        end else begin
            chk({tag, " R3 inject"}, inject_en, 0);
            chk({tag, " R3 stage/swap"}, {stage_on, swap_pol}, e - 2);
        end
        chk("R10 pga_coef hold", pga_coef, pga_m);
        chk("R10 fga_coef hold", fga_coef, fga_m);
        exp_q.push_back(corr(code, fx ? fga_m : pga_m));
        tag_q.push_back({tag, " R7 out_code"});
        smp_code = 24'(code);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        unique case (e)
            0: begin hold = code; ph = 1; end
            1: begin
                if (ref_step != 0) pga_m = quot(absl(code - hold), ref_step);
                ph = 0;
            end
            2: begin hold = code; ph = 3; end
            3: begin half_off = (hold - code) >>> 1; ph = 4; end
            4: begin hold = code; ph = 5; end
            default: begin
                if (half_off != 0) fga_m = quot(absl((hold - code) >>> 1), absl(half_off));
                ph = 2;
            end
        endcase
        repeat (70) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected out_valid", 1, 0);
            end else begin
                longint ex;
                string tg;
                ex = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(tg, longint'(out_code), ex);
            end
        end
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pga_coef reset", pga_coef, 64'h400000);
        chk("R1 fga_coef reset", fga_coef, 64'h400000);
        chk("R1 out_valid reset", out_valid, 0);
        chk("R1 strobes reset", {inject_en, stage_on, swap_pol}, 0);

        // programmable-gain pair, positive step
        send(0, 1000, "pa");
        send(0, 1000 + 24'h120000, "pb");
        chk("R4 pga_coef 1.125", pga_coef, 64'h480000);
        // negative step, scaled samples
        send(0, 100000, "pc");
        send(0, 100000 - 24'h080000, "pd");
        chk("R4 pga_coef 0.5", pga_coef, 64'h200000);
        // zero denominator skip
        ref_step = 24'h0;
        send(0, 7, "pe");
        send(0, 5000, "pf");
        chk("R6 pga_coef kept", pga_coef, 64'h200000);
        // coefficient saturation
        ref_step = 24'h1;
        send(0, 0, "pg");
        send(0, 200, "ph");
        chk("R4 pga_coef saturated", pga_coef, 64'hFFFFFF);
        // output saturation
        send(0, 8388607, "R9 pos");
        send(0, -8388608, "R9 neg");
        // switch to fixed mode mid-pair
        ref_step = 24'h100000;
        send(0, 10, "pi");
        send(1, 5000, "R8 to fixed");
        send(1, -5000, "fb");
        send(1, 6000, "fc");
        send(1, -6000, "fd");
        chk("R5 fga_coef 1.2", fga_coef, (64'd6000 <<< 22) / 64'd5000);
        // odd and negative halving
        send(1, 0, "fe");
        send(1, 5001, "ff");
        send(1, 5001, "fg");
        send(1, 0, "fh");
        chk("R5 fga_coef floor halving", fga_coef, (64'd2500 <<< 22) / 64'd2501);
        // zero halved off-difference skip
        send(1, 7, "fi");
        send(1, 7, "fj");
        send(1, 100, "fk");
        send(1, -100, "fl");
        chk("R6 fga_coef kept", fga_coef, (64'd2500 <<< 22) / 64'd2501);
        // switch back mid fixed cycle
        send(1, 3, "fm");
        send(0, 2000, "R8 to pga");
        send(0, 2000 + 24'h100000, "pj");
        chk("R4 pga_coef unity", pga_coef, 64'h400000);
        send(1, -3, "fn");
        send(1, 1234567, "fo");
        send(0, -77, "pk");

        repeat (5) @(negedge clk);
        chk("R7 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule